// File: doc/BRIEF.md
# Sleep-State Power Rail Controller

This block turns a pair of active-low sleep request pins into one of three power states: running, suspend-to-RAM, or suspend-to-disk/soft-off. From that state it drives on/off controls for a 3.3 V auxiliary rail, a 5 V auxiliary rail and a memory rail, and it drives the memory rail's 2.5 V / 3.3 V select. Each auxiliary rail has a keep-alive strap that decides whether the rail stays powered while the system sleeps. The straps are captured only while the system is running, while the power-on-reset input is high, or while the shutdown input is high. Outside those windows the captured copy is frozen.

The pins pass through a synchronizer and then a deglitch timer. A pin change is acted on only once the sampled pair has stayed steady for a full timeout. The timeout is computed from the clock frequency and a time parameter. The controller holds its state when the pins present the forbidden code. It also holds its state when a request would move directly from one sleep state to the other. Only moves between running and a sleep state are taken.

All ports are plain level signals with no handshake. The straps, memory select, power-on-reset and shutdown inputs are taken to be synchronous to the clock.

Top module: `psc_rail_ctrl`

## Requirements
- R1: The pair {sleep_off_n, sleep_ram_n} decodes to a state: 11 gives running (pstate 2'b00), 10 gives suspend-to-RAM (pstate 2'b01), and 00 gives soft-off (pstate 2'b10). pstate never reads 2'b11.
- R2: The pair 01 (sleep_off_n=0, sleep_ram_n=1) is forbidden. While it is present, pstate keeps its previous value.
- R3: From suspend-to-RAM, a request for soft-off is refused, and from soft-off a request for suspend-to-RAM is refused. In both cases pstate is kept. A sleep state can only be left for running.
- R4: mem_rail_on is 1 in running and in suspend-to-RAM, and 0 in soft-off. mem_v33 follows mem_v33_sel: 1 selects 3.3 V and 0 selects 2.5 V.
- R5: rail3v_on and rail5v_on are 1 in running. In either sleep state, each is 1 only if its captured keep-alive strap is 1.
- R6: The straps hold3v_strap and hold5v_strap are captured only while pstate is running, por_i is 1, or shutdown_i is 1. A strap change made in a sleep state outside those windows has no effect on the rails.
- R7: A change of the sampled pin pair is adopted only after the pair has stayed unchanged for DG_CYCLES = CLK_KHZ*DEGLITCH_NS/1e6 cycles. A new change restarts the timer. If the pair returns to its earlier code before expiry, the state is unchanged. The new state appears within DG_CYCLES+6 cycles of the pin change.
- R8: While por_i is 1, pstate is forced to running and every rail output is 0. The straps present when por_i falls are the ones used afterwards.
- R9: While shutdown_i is 1, every rail output is 0. State decisions continue, and strap changes are captured even in a sleep state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_ram_n | input | 1 | Suspend-to-RAM request pin, active low, asynchronous |
| sleep_off_n | input | 1 | Soft-off request pin, active low, asynchronous |
| hold3v_strap | input | 1 | Keep the 3.3 V auxiliary rail on in sleep |
| hold5v_strap | input | 1 | Keep the 5 V auxiliary rail on in sleep |
| mem_v33_sel | input | 1 | Memory voltage select: 1 for 3.3 V, 0 for 2.5 V |
| por_i | input | 1 | Bias below power-on-reset level |
| shutdown_i | input | 1 | Chip shutdown request |
| rail3v_on | output | 1 | 3.3 V auxiliary rail enable |
| rail5v_on | output | 1 | 5 V auxiliary rail enable |
| mem_rail_on | output | 1 | Memory rail enable |
| mem_v33 | output | 1 | Memory rail at 3.3 V when 1, 2.5 V when 0 |
| pstate | output | 2 | Current power state: 00 running, 01 suspend-to-RAM, 10 soft-off |

## Verification
Shutdown gating of the rails and the deglitch timer's state decision can land in the same cycle. This is the case where they interact. The bench holds shutdown_i high across two full deglitch windows: one that returns the system to running and one that enters suspend-to-RAM. It also rewrites the straps during that time. It then judges that pstate moved while all three rails stayed off. After shutdown is released, the rails must follow the new state with the straps written during shutdown. A second coincidence is the strap window closing in the very cycle the state leaves running. The bench covers this by checking that a strap change made only after entry to sleep has no effect.

// File: rtl/psc_pkg.sv
package psc_pkg;

  typedef enum logic [1:0] {
    PS_RUN = 2'b00,
    PS_STR = 2'b01,
    PS_OFF = 2'b10
  } pstate_e;

  typedef struct packed {
    logic    valid;
    pstate_e target;
  } req_t;

  // pair = {sleep_off_n, sleep_ram_n}
  function automatic req_t decode_pair(input logic [1:0] pair);
    req_t r;
    r.valid  = 1'b1;
    r.target = PS_RUN;
    unique case (pair)
      2'b11:   r.target = PS_RUN;
      2'b10:   r.target = PS_STR;
      2'b00:   r.target = PS_OFF;
      default: r.valid  = 1'b0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/psc_pin_sync.sv
module psc_pin_sync #(
  parameter int          WIDTH     = 2,
  parameter int          STAGES    = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [WIDTH-1:0] stg_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= d_i;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg_q[s] <= RST_VAL;
          else        stg_q[s] <= stg_q[s-1];
        end
      end
    end
  endgenerate

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/psc_deglitch.sv
module psc_deglitch #(
  parameter int CYCLES = 40000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clear_i,
  input  logic [1:0] pair_i,
  output logic       fire_o,
  output logic [1:0] req_o
);

  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST_CNT = CW'(CYCLES - 1);

  logic [1:0]    last_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic          fire_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_q <= 2'b11;
      cnt_q  <= '0;
      run_q  <= 1'b0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (clear_i) begin
        last_q <= pair_i;
        cnt_q  <= '0;
        run_q  <= 1'b0;
      end else if (pair_i != last_q) begin
        last_q <= pair_i;
        cnt_q  <= '0;
        run_q  <= 1'b1;
      end else if (run_q) begin
        if (cnt_q == LAST_CNT) begin
          run_q  <= 1'b0;
          fire_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign fire_o = fire_q;
  assign req_o  = last_q;

endmodule

// File: rtl/psc_state_fsm.sv
module psc_state_fsm
  import psc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       force_run_i,
  input  logic       fire_i,
  input  logic [1:0] req_i,
  output pstate_e    state_o
);

  pstate_e state_q, state_d;
  req_t    req;

  always_comb begin
    req     = decode_pair(req_i);
    state_d = state_q;
    if (force_run_i) begin
      state_d = PS_RUN;
    end else if (fire_i && req.valid) begin
      // sleep-to-sleep hops are refused; running is reachable from anywhere
      if (state_q == PS_RUN || req.target == PS_RUN)
        state_d = req.target;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PS_RUN;
    else        state_q <= state_d;
  end

  assign state_o = state_q;

endmodule

// File: rtl/psc_strap_latch.sv
module psc_strap_latch #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         open_i,
  input  logic [N-1:0] strap_i,
  output logic [N-1:0] strap_o
);

  logic [N-1:0] strap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      strap_q <= '0;
    else if (open_i) strap_q <= strap_i;
  end

  assign strap_o = strap_q;

endmodule

// File: rtl/psc_rail_drive.sv
module psc_rail_drive
  import psc_pkg::*;
#(
  parameter int N_AUX = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  pstate_e          state_i,
  input  logic [N_AUX-1:0] keep_i,
  input  logic             mem_sel_i,
  input  logic             kill_i,
  output logic [N_AUX-1:0] aux_on_o,
  output logic             mem_on_o,
  output logic             mem_v33_o
);

  logic running;
  assign running = (state_i == PS_RUN);

  generate
    for (genvar i = 0; i < N_AUX; i++) begin : g_aux
      logic on_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) on_q <= 1'b0;
        else        on_q <= !kill_i && (running || keep_i[i]);
      end
      assign aux_on_o[i] = on_q;
    end
  endgenerate

  logic mem_on_q, mem_v33_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_on_q  <= 1'b0;
      mem_v33_q <= 1'b0;
    end else begin
      mem_on_q  <= !kill_i && (state_i != PS_OFF);
      mem_v33_q <= mem_sel_i;
    end
  end

  assign mem_on_o  = mem_on_q;
  assign mem_v33_o = mem_v33_q;

endmodule

// File: rtl/psc_rail_ctrl.sv
module psc_rail_ctrl
  import psc_pkg::*;
#(
  parameter int CLK_KHZ     = 200000,
  parameter int DEGLITCH_NS = 200000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sleep_ram_n,
  input  logic       sleep_off_n,
  input  logic       hold3v_strap,
  input  logic       hold5v_strap,
  input  logic       mem_v33_sel,
  input  logic       por_i,
  input  logic       shutdown_i,
  output logic       rail3v_on,
  output logic       rail5v_on,
  output logic       mem_rail_on,
  output logic       mem_v33,
  output logic [1:0] pstate
);

  localparam longint DG_RAW    = (longint'(CLK_KHZ) * longint'(DEGLITCH_NS)) / 64'sd1000000;
  localparam int     DG_CYCLES = (DG_RAW < 1) ? 1 : int'(DG_RAW);
  localparam int     N_AUX     = 2;

  logic [1:0]       pair_s;
  logic             fire;
  logic [1:0]       req;
  pstate_e          state;
  logic [N_AUX-1:0] keep_q;
  logic [N_AUX-1:0] aux_on;
  logic             strap_open;

  psc_pin_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d_i  ({sleep_off_n, sleep_ram_n}),
    .q_o  (pair_s)
  );

  psc_deglitch #(.CYCLES(DG_CYCLES)) u_dg (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear_i(por_i),
    .pair_i (pair_s),
    .fire_o (fire),
    .req_o  (req)
  );

  psc_state_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .force_run_i(por_i),
    .fire_i     (fire),
    .req_i      (req),
    .state_o    (state)
  );

  assign strap_open = (state == PS_RUN) || por_i || shutdown_i;

  psc_strap_latch #(.N(N_AUX)) u_strap (
    .clk    (clk),
    .rst_n  (rst_n),
    .open_i (strap_open),
    .strap_i({hold5v_strap, hold3v_strap}),
    .strap_o(keep_q)
  );

  psc_rail_drive #(.N_AUX(N_AUX)) u_drv (
    .clk      (clk),
    .rst_n    (rst_n),
    .state_i  (state),
    .keep_i   (keep_q),
    .mem_sel_i(mem_v33_sel),
    .kill_i   (por_i || shutdown_i),
    .aux_on_o (aux_on),
    .mem_on_o (mem_rail_on),
    .mem_v33_o(mem_v33)
  );

  assign rail3v_on = aux_on[0];
  assign rail5v_on = aux_on[1];
  assign pstate    = state;

endmodule

// File: rtl/psc_rail_chk.sv
module psc_rail_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       por_i,
  input logic       shutdown_i,
  input logic       rail3v_on,
  input logic       rail5v_on,
  input logic       mem_rail_on,
  input logic [1:0] pstate
);

  AST_STATE_CODE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pstate != 2'b11); // R1

  AST_NO_SLEEP_HOP: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate != 2'b00) |=> (pstate == $past(pstate) || pstate == 2'b00)); // R3

  AST_MEM_OFF_SOFTOFF: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'b10) |=> !mem_rail_on); // R4

  AST_RUN_RAILS_ON: assert property (@(posedge clk) disable iff (!rst_n)
    (pstate == 2'b00 && !por_i && !shutdown_i) |=> (rail3v_on && rail5v_on && mem_rail_on)); // R5

  AST_POR_FORCES_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    por_i |=> (pstate == 2'b00 && !rail3v_on && !rail5v_on && !mem_rail_on)); // R8

  AST_SHDN_RAILS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    shutdown_i |=> (!rail3v_on && !rail5v_on && !mem_rail_on)); // R9

endmodule

bind psc_rail_ctrl psc_rail_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .por_i      (por_i),
  .shutdown_i (shutdown_i),
  .rail3v_on  (rail3v_on),
  .rail5v_on  (rail5v_on),
  .mem_rail_on(mem_rail_on),
  .pstate     (pstate)
);

// File: tb/test_psc_rail_ctrl.sv
module test_psc_rail_ctrl;

  localparam int CLK_KHZ = 200000;
  localparam int DG_NS   = 100;
  localparam int DG      = 20;           // 200000 * 100 / 1e6
  localparam int SETTLE  = DG + 10;

  localparam logic [1:0] RUN = 2'b00, STR = 2'b01, OFF = 2'b10;

  // {sleep_off_n, sleep_ram_n, expected pstate}
  localparam int NV = 10;
  localparam logic [3:0] VEC [NV] = '{
    4'b10_01, 4'b00_01, 4'b11_00, 4'b00_10, 4'b10_10,
    4'b01_10, 4'b11_00, 4'b01_00, 4'b00_10, 4'b11_00
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sleep_ram_n = 1'b1, sleep_off_n = 1'b1;
  logic hold3v_strap = 1'b1, hold5v_strap = 1'b0;
  logic mem_v33_sel = 1'b1, por_i = 1'b1, shutdown_i = 1'b0;
  logic rail3v_on, rail5v_on, mem_rail_on, mem_v33;
  logic [1:0] pstate;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  psc_rail_ctrl #(.CLK_KHZ(CLK_KHZ), .DEGLITCH_NS(DG_NS)) i_psc_rail_ctrl (
    .clk(clk), .rst_n(rst_n), .sleep_ram_n(sleep_ram_n), .sleep_off_n(sleep_off_n),
    .hold3v_strap(hold3v_strap), .hold5v_strap(hold5v_strap), .mem_v33_sel(mem_v33_sel),
    .por_i(por_i), .shutdown_i(shutdown_i), .rail3v_on(rail3v_on), .rail5v_on(rail5v_on),
    .mem_rail_on(mem_rail_on), .mem_v33(mem_v33), .pstate(pstate)
  );

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_rails(input string req, input logic r3, input logic r5, input logic m);
    check(req, "rails{3v,5v,mem}", {1'b0, rail3v_on, rail5v_on, mem_rail_on}, {1'b0, r3, r5, m});
  endtask

  task automatic set_pins(input logic off_n, input logic ram_n);
    sleep_off_n = off_n;
    sleep_ram_n = ram_n;
  endtask

  initial begin
    wait_cyc(3);
    check("R8", "reset pstate", {2'b0, pstate}, {2'b0, RUN});
    check_rails("R8", 0, 0, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check("R8", "por pstate", {2'b0, pstate}, {2'b0, RUN});
    check_rails("R8", 0, 0, 0);
    por_i = 1'b0;                       // straps 3v=1, 5v=0 loaded here
    wait_cyc(3);
    check_rails("R5", 1, 1, 1);
    check("R4", "mem_v33", {3'b0, mem_v33}, 4'd1);

    // table walk: straps 3v=1, 5v=0
    for (int i = 0; i < NV; i++) begin
      logic [1:0] es;
      string tag;
      es = VEC[i][1:0];
      set_pins(VEC[i][3], VEC[i][2]);
      wait_cyc(SETTLE);
      if (VEC[i][3:2] == 2'b01) tag = "R2";
      else if ((VEC[i][3:2] == 2'b10 && es != STR) || (VEC[i][3:2] == 2'b00 && es != OFF)) tag = "R3";
      else tag = "R1";
      check(tag, $sformatf("vec %0d pstate", i), {2'b0, pstate}, {2'b0, es});
      check_rails("R5", 1'b1, es == RUN, es != OFF);
    end

    // R7: not adopted before the timeout, adopted after it
    set_pins(1, 0);
    wait_cyc(DG / 2);
    check("R7", "mid-timeout pstate", {2'b0, pstate}, {2'b0, RUN});
    wait_cyc(DG / 2 + 6);
    check("R7", "post-timeout pstate", {2'b0, pstate}, {2'b0, STR});
    set_pins(1, 1);
    wait_cyc(SETTLE);
    // R7: short glitch returns to the earlier code
    set_pins(0, 0);
    wait_cyc(5);
    set_pins(1, 1);
    wait_cyc(SETTLE);
    check("R7", "glitch pstate", {2'b0, pstate}, {2'b0, RUN});
    // R7: second change restarts the timer
    set_pins(1, 0);
    wait_cyc(DG - 5);
    set_pins(0, 0);
    wait_cyc(11);
    check("R7", "restart pstate", {2'b0, pstate}, {2'b0, RUN});
    wait_cyc(DG);
    check("R7", "after restart pstate", {2'b0, pstate}, {2'b0, OFF});

    // R6: strap change in sleep is ignored
    check_rails("R4", 1, 0, 0);
    hold3v_strap = 1'b0;
    hold5v_strap = 1'b1;
    wait_cyc(5);
    check_rails("R6", 1, 0, 0);
    set_pins(1, 1);
    wait_cyc(SETTLE);                   // running: straps now 3v=0, 5v=1
    set_pins(1, 0);
    wait_cyc(SETTLE);
    check("R1", "str pstate", {2'b0, pstate}, {2'b0, STR});
    check_rails("R6", 0, 1, 1);
    mem_v33_sel = 1'b0;
    wait_cyc(3);
    check("R4", "mem_v33 2.5V", {3'b0, mem_v33}, 4'd0);

    // R9: shutdown coinciding with deglitch decisions
    shutdown_i = 1'b1;
    wait_cyc(3);
    check_rails("R9", 0, 0, 0);
    hold3v_strap = 1'b1;
    hold5v_strap = 1'b0;
    set_pins(1, 1);
    wait_cyc(SETTLE);
    check("R9", "shdn pstate run", {2'b0, pstate}, {2'b0, RUN});
    check_rails("R9", 0, 0, 0);
    set_pins(1, 0);
    wait_cyc(SETTLE);
    check("R9", "shdn pstate str", {2'b0, pstate}, {2'b0, STR});
    check_rails("R9", 0, 0, 0);
    shutdown_i = 1'b0;
    wait_cyc(3);
    check_rails("R9", 1, 0, 1);

    // R8: power-on-reset while asleep
    por_i = 1'b1;
    set_pins(1, 1);
    wait_cyc(3);
    check("R8", "por pstate", {2'b0, pstate}, {2'b0, RUN});
    check_rails("R8", 0, 0, 0);
    hold5v_strap = 1'b1;
    por_i = 1'b0;
    wait_cyc(SETTLE);
    check("R8", "after por pstate", {2'b0, pstate}, {2'b0, RUN});
    check_rails("R8", 1, 1, 1);
    set_pins(0, 0);
    wait_cyc(SETTLE);
    check_rails("R8", 1, 1, 0);

    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule